// File: doc/BRIEF.md
# Scratch / FIFO-Level Swap Register

This block is one slot of a UART host register file. At a single register address it behaves in one of two ways, chosen by a swap control input. With swap low, the slot is an ordinary 8-bit scratch register that software can write and read back. With swap high, the same address takes on two new meanings. A write loads a small write-only mode field. A read returns the occupancy of the receive or transmit FIFO, and the mode field chooses which one.

One mode interleaves the two counts. The first read after the mode is written returns the receive count, the next read returns the transmit count, and the two keep alternating. A host can therefore poll both FIFO levels through one address without rewriting the mode. The scratch value survives sleep, and it survives any amount of swap-mode traffic.

The read bus is combinational from the stored state, the swap input and the FIFO counts. The value a read strobe picks up is therefore valid in the cycle in which that strobe is sampled.

Top module: `aux_reg_slot`

## Requirements
- R1: With swap low, a selected write stores all 8 bits of the write bus, and later reads with swap low return that byte.
- R2: After reset the scratch register reads 0xFF and the mode field is 00, so a read with swap high returns the receive count.
- R3: Holding the sleep input high for any number of cycles leaves the scratch contents unchanged.
- R4: With swap high, a selected write changes the mode field and leaves the scratch contents untouched.
- R5: With swap high, a read returns the receive count for mode 00 or 10 and the transmit count for mode 01. The mode is taken from bits [1:0] of the last swap-high write.
- R6: In mode 11, the first read after the mode write returns the receive count, the second returns the transmit count, and later reads keep alternating.
- R7: Bits [7:2] of a swap-high write have no effect: writing 0xFC|m behaves exactly like writing m.
- R8: The alternation step advances only on a cycle where select and read strobe are both high and swap is high. Idle cycles and unselected read strobes do not advance it.
- R9: A mode write, or any change of the swap input, returns the alternation to its receive phase.
- R10: FIFO counts from 0 to 128 appear on the read bus unmodified, in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register-select strobe for this address |
| rd_stb | input | 1 | Read strobe, single-cycle pulse |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data bus |
| swap_en | input | 1 | High: the address maps to mode / FIFO level |
| sleep | input | 1 | Sleep indicator; the scratch register retains its value |
| rx_count | input | 8 | Current receive FIFO occupancy (0..128) |
| tx_count | input | 8 | Current transmit FIFO occupancy (0..128) |
| rd_data | output | 8 | Read data bus |

## Verification
The bench goes after the alternation phase. It checks that a fresh mode write, or a swap toggle while already in the transmit phase, restarts the sequence at the receive count. It also checks that idle cycles and unselected read strobes leave the phase unchanged. A design that missed either point would return the transmit count where the receive count was due.

It writes the mode with the reserved upper bits set, to catch a decoder that looks at the whole byte. Such a decoder would select the wrong FIFO. After the swap-high writes it reads the scratch register back, which exposes a design that lets those writes fall through to the scratch store.

Every count from 0 to 128 is swept against every mode, so a narrowed or remapped count path would return a wrong number.

// File: rtl/aux_slot_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the scratch / FIFO-level slot.
// Assumes the level mode field is two bits wide.
package aux_slot_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        LVL_RX        = 2'b00,
        LVL_TX        = 2'b01,
        LVL_RX_ALT    = 2'b10,
        LVL_ALTERNATE = 2'b11
    } lvl_mode_e;
endpackage

// File: rtl/aux_scratch_store.sv
`timescale 1ns/1ps
// Module: aux_scratch_store
// Holds the general-purpose scratch byte. It loads on wr_en and holds otherwise.
// Assumes sleep never clears state: retention is simply the absence of writes.
module aux_scratch_store #(
    parameter int            DATA_W = 8,
    parameter logic [DATA_W-1:0] INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sleep,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);
    logic sleep_unused;
    assign sleep_unused = sleep;

    // Scratch byte: reset to INIT, load on write enable only.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= INIT;
        else if (wr_en) q <= wr_data;
    end

    // Without a write the stored byte must hold, whatever sleep does.
    assert_sleep_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !wr_en) |=> $stable(q));
endmodule

// File: rtl/aux_level_select.sv
`timescale 1ns/1ps
// Module: aux_level_select
// Keeps the write-only level mode and the alternation phase, and picks which
// FIFO count goes onto the read path.
// Assumes rd_fire is a single-cycle pulse already qualified by select and swap.
module aux_level_select
    import aux_slot_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic              rd_fire,
    input  logic              swap_en,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    output logic [DATA_W-1:0] level
);
    localparam int PAD_W = DATA_W - CNT_W;

    lvl_mode_e        mode_q;
    logic             phase_q;    // 0: next alternating read is RX, 1: TX
    logic             swap_q;
    logic             swap_flip;
    logic             phase_eff;
    logic             alt_mode;
    logic             pick_tx;
    logic [CNT_W-1:0] cnt_sel;

    // Swap edge detection and the phase actually seen by this cycle's read.
    always_comb begin
        swap_flip = (swap_en != swap_q);
        phase_eff = swap_flip ? 1'b0 : phase_q;
        alt_mode  = (mode_q == LVL_ALTERNATE);
        pick_tx   = alt_mode ? phase_eff : (mode_q == LVL_TX);
        cnt_sel   = pick_tx ? tx_count : rx_count;
    end

    // Mode field: loaded from the low bits of a swap-high write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= LVL_RX;
        else if (mode_wr) mode_q <= lvl_mode_e'(wr_mode);
    end

    // Alternation phase: a mode write clears it, a read steps it, a swap edge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            swap_q  <= 1'b0;
        end else begin
            swap_q <= swap_en;
            if (mode_wr)                   phase_q <= 1'b0;
            else if (rd_fire && alt_mode)  phase_q <= ~phase_eff;
            else if (swap_flip)            phase_q <= 1'b0;
        end
    end

    // Width adaptation of the selected count onto the data bus.
    generate
        if (PAD_W > 0) begin : g_pad
            assign level = {{PAD_W{1'b0}}, cnt_sel};
        end else begin : g_direct
            assign level = cnt_sel[DATA_W-1:0];
        end
    endgenerate

    assert_mode_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode_q == lvl_mode_e'($past(wr_mode)));
    assert_phase_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !phase_q);
    assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && alt_mode && !mode_wr) |=> phase_q != $past(phase_eff));
    assert_phase_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_fire && !mode_wr && !swap_flip) |=> $stable(phase_q));
endmodule

// File: rtl/aux_reg_slot.sv
`timescale 1ns/1ps
// Module: aux_reg_slot (top)
// One register address that acts as a scratch byte (swap low) or as
// a mode / FIFO-level port (swap high). The read bus is combinational.
// Assumes strobes are synchronous to clk and rd_stb is a one-cycle pulse.
module aux_reg_slot
    import aux_slot_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              swap_en,
    input  logic              sleep,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    output logic [DATA_W-1:0] rd_data
);
    logic              scratch_we;
    logic              mode_we;
    logic              rd_fire;
    logic [DATA_W-1:0] scratch_val;
    logic [DATA_W-1:0] level_val;

    // Address decode: the swap bit steers writes and qualifies reads.
    always_comb begin
        scratch_we = sel && wr_stb && !swap_en;
        mode_we    = sel && wr_stb && swap_en;
        rd_fire    = sel && rd_stb && swap_en;
    end

    aux_scratch_store #(.DATA_W(DATA_W), .INIT({DATA_W{1'b1}})) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (scratch_we),
        .sleep   (sleep),
        .wr_data (wr_data),
        .q       (scratch_val)
    );

    aux_level_select #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_we),
        .wr_mode  (wr_data[MODE_W-1:0]),
        .rd_fire  (rd_fire),
        .swap_en  (swap_en),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .level    (level_val)
    );

    // Read mux: scratch byte or FIFO level.
    assign rd_data = swap_en ? level_val : scratch_val;

    assert_scratch_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_stb && swap_en) |=> $stable(scratch_val));
    assert_scratch_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_stb && !swap_en) |=> (swap_en || rd_data == $past(wr_data)));
endmodule

// File: tb/aux_reg_slot_tb.sv
`timescale 1ns/1ps
module aux_reg_slot_tb;
    logic       clk = 1'b0;
    logic       rst_n, sel, rd_stb, wr_stb, swap_en, sleep;
    logic [7:0] wr_data, rx_count, tx_count, rd_data;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    logic [7:0] m_scratch;
    logic [1:0] m_mode;
    bit         m_phase;

    always #2.5 clk = ~clk;

    aux_reg_slot u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .swap_en(swap_en), .sleep(sleep),
        .rx_count(rx_count), .tx_count(tx_count), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        sel = 1; wr_stb = 1; wr_data = v;
        @(posedge clk); #1;
        sel = 0; wr_stb = 0;
        if (swap_en) begin m_mode = v[1:0]; m_phase = 0; end
        else m_scratch = v;
    endtask

    task automatic do_read(output logic [7:0] got);
        @(negedge clk);
        sel = 1; rd_stb = 1;
        #1 got = rd_data;
        @(posedge clk); #1;
        sel = 0; rd_stb = 0;
    endtask

    // Model of the expected swap-high read; steps the model phase.
    function automatic logic [7:0] exp_level();
        logic [7:0] e;
        if (m_mode == 2'b11) begin
            e = m_phase ? tx_count : rx_count;
            m_phase = !m_phase;
        end else begin
            e = (m_mode == 2'b01) ? tx_count : rx_count;
        end
        return e;
    endfunction

    task automatic set_swap(input logic b);
        @(negedge clk);
        swap_en = b;
        m_phase = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, e;
        rst_n = 0; sel = 0; rd_stb = 0; wr_stb = 0; wr_data = 0;
        swap_en = 0; sleep = 0; rx_count = 8'd37; tx_count = 8'd90;
        m_scratch = 8'hFF; m_mode = 0; m_phase = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R2: reset values
        do_read(got); check("R2 scratch reset", got, 8'hFF);
        set_swap(1);
        do_read(got); check("R2 mode reset", got, 8'd37);
        set_swap(0);

        // R1: every byte value round-trips
        for (int v = 0; v < 256; v++) begin
            do_write(v[7:0]);
            do_read(got); check("R1 readback", got, m_scratch);
        end

        // R3: retention across sleep
        do_write(8'h5A);
        @(negedge clk) sleep = 1;
        repeat (50) @(posedge clk);
        do_read(got); check("R3 during sleep", got, 8'h5A);
        @(negedge clk) sleep = 0;
        do_read(got); check("R3 after sleep", got, 8'h5A);

        // R5 R6 R7 R10: all modes, with and without reserved bits, all counts
        set_swap(1);
        for (int hi = 0; hi < 2; hi++) begin
            for (int m = 0; m < 4; m++) begin
                do_write(hi ? (8'hFC | m[7:0]) : m[7:0]);
                for (int c = 0; c <= 128; c++) begin
                    @(negedge clk);
                    rx_count = c[7:0]; tx_count = 8'(128 - c);
                    e = exp_level();
                    do_read(got);
                    if (m == 3)  check("R6 alternate", got, e);
                    else if (hi) check("R7 reserved bits", got, e);
                    else         check("R5 R10 level", got, e);
                end
            end
        end

        // R4: swap-high writes left the scratch alone
        set_swap(0);
        do_read(got); check("R4 scratch kept", got, 8'h5A);

        // R8: idle cycles and unselected strobes do not step the phase
        set_swap(1);
        rx_count = 8'd11; tx_count = 8'd99;
        do_write(8'h03);
        do_read(got); check("R8 first", got, 8'd11);
        repeat (10) @(posedge clk);
        @(negedge clk) rd_stb = 1;
        @(negedge clk) rd_stb = 0;
        do_read(got); check("R8 after idle", got, 8'd99);
        do_read(got); check("R8 next", got, 8'd11);

        // R9: swap toggle and mode rewrite restart at RX
        set_swap(0);
        set_swap(1);
        do_read(got); check("R9 swap toggle", got, 8'd11);
        do_read(got); check("R9 then tx", got, 8'd99);
        do_write(8'h03);
        do_read(got); check("R9 mode rewrite", got, 8'd11);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule